// File: doc/BRIEF.md
# IN Endpoint Retransmit Buffer

This block sits between a device function and the IN FIFO of a USB 1.1 device core that serves a bulk or interrupt IN endpoint. The function hands over one packet at a time as a byte stream, with the final byte flagged. The block keeps that packet in a local copy and writes it into the core's IN FIFO. The core does not resend a packet that the host fails to acknowledge, so the retry is done here, outside the core.

Once the packet has been written, the block waits for the core's status events. A timeout event that arrives while the selected endpoint equals this block's endpoint number causes the whole stored packet to be written into the FIFO again, starting from its first byte. An acknowledge event for the same endpoint frees the copy, so the block can accept the next packet from the function. Retries are counted. When the count is used up, a sticky error flag is raised and the packet is dropped instead of sent again. The core's token handling and data toggle stay in the core.

Top module: `inRetryBuf`

## Requirements
- R1: After reset, ldReady is 1, fifoWe is 0 and retryErr is 0.
- R2: When the byte marked ldLast is accepted, the stored bytes are written to the FIFO in load order, starting with the first. fifoWe first rises in the cycle after that acceptance. One byte is written per cycle while fifoFull is low, and exactly as many bytes are written as were loaded.
- R3: From the acceptance of the last byte until the packet is released, ldReady is 0. Any ldValid/ldData driven in that time is ignored and does not alter the stored copy.
- R4: A toPulse with epSel equal to EP_ID, after the packet has been written and while it awaits acknowledge, writes the complete stored packet into the FIFO again from byte 0.
- R5: An ackPulse with epSel equal to EP_ID while the packet awaits acknowledge releases it: ldReady is 1 in the next cycle and the retry count returns to zero.
- R6: A toPulse or ackPulse with epSel not equal to EP_ID has no effect. No FIFO write follows and ldReady stays 0.
- R7: While fifoFull is 1, fifoWe is 0 and the replay position holds, so no byte is skipped or repeated.
- R8: At most MAX_RETRY timeouts in a row lead to a replay. The next matching timeout sets retryErr, writes nothing and releases the packet (ldReady returns to 1).
- R9: retryErr stays 1 until reset, through later packets and acknowledges.
- R10: The copy holds DEPTH bytes (default 64). The DEPTH-th byte of a packet is treated as its last byte even when ldLast is 0.
- R11: If a matching ackPulse and toPulse arrive in the same cycle, the acknowledge wins and no replay follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Function offers a packet byte |
| ldData | input | 8 | Packet byte from the function |
| ldLast | input | 1 | Marks the final byte of the packet |
| ldReady | output | 1 | Block accepts a byte (no packet outstanding) |
| fifoWe | output | 1 | Write strobe into the core's IN FIFO |
| fifoDin | output | 8 | Byte written into the IN FIFO |
| fifoFull | input | 1 | IN FIFO cannot take a byte |
| toPulse | input | 1 | Core timeout event (one cycle) |
| ackPulse | input | 1 | Core acknowledge-received event (one cycle) |
| epSel | input | EP_W | Endpoint currently selected by the core |
| retryErr | output | 1 | Sticky: retry limit exhausted |

## Verification
Several properties hold on every cycle and are checked continuously: no FIFO write while the FIFO reports full, no load acceptance during a write, a sticky error flag, release after a matching acknowledge, and no reaction to events addressed to another endpoint. Other behaviours can only be shown by the bench's scenarios, because they depend on the content and count of the bytes across a whole packet. These are byte-exact replay from the first byte, the stall-and-resume order under a full FIFO, truncation at the buffer capacity, the exact retry at which the error fires, and acknowledge winning over a same-cycle timeout.

// File: rtl/inRetryPkg.sv
package inRetryPkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic store;   // write incoming byte into the copy
    logic send;    // replay phase active
    logic advance; // current byte accepted by the FIFO
  } ctlStrb_t;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } rbState_t;
endpackage

// File: rtl/inRetryData.sv
module inRetryData
  import inRetryPkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrb_t   strb,
  input  logic [7:0] ldData,
  input  logic       ldLast,
  output logic       loadLast,
  output logic       sendDone,
  output logic [7:0] fifoDin
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]  mem [DEPTH];
  logic [AW-1:0] wrCnt;
  logic [AW-1:0] rdPtr;
  logic [AW:0]   pktLen;

  assign loadLast = ldLast || (wrCnt == AW'(DEPTH - 1));
  assign sendDone = ({1'b0, rdPtr} + 1'b1) == pktLen;
  assign fifoDin  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.store) mem[wrCnt] <= ldData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt  <= '0;
      rdPtr  <= '0;
      pktLen <= '0;
    end else begin
      if (strb.store) begin
        if (loadLast) begin
          wrCnt  <= '0;
          pktLen <= {1'b0, wrCnt} + 1'b1;
        end else begin
          wrCnt <= wrCnt + 1'b1;
        end
      end
      if (!strb.send) rdPtr <= '0;
      else if (strb.advance) rdPtr <= sendDone ? '0 : rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/inRetryCtl.sv
module inRetryCtl
  import inRetryPkg::*;
#(
  parameter int MAX_RETRY = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ldValid,
  input  logic     loadLast,
  input  logic     sendDone,
  input  logic     fifoFull,
  input  logic     toHit,
  input  logic     ackHit,
  output logic     ldReady,
  output logic     fifoWe,
  output logic     retryErr,
  output ctlStrb_t strb
);
  localparam int RW = $clog2(MAX_RETRY + 1);

  rbState_t state;
  logic [RW-1:0] retryCnt;

  assign ldReady      = (state == ST_LOAD);
  assign fifoWe       = (state == ST_SEND) && !fifoFull;
  assign strb.store   = ldReady && ldValid;
  assign strb.send    = (state == ST_SEND);
  assign strb.advance = fifoWe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_LOAD;
      retryCnt <= '0;
      retryErr <= 1'b0;
    end else begin
      unique case (state)
        ST_LOAD: if (strb.store && loadLast) state <= ST_SEND;
        ST_SEND: if (strb.advance && sendDone) state <= ST_WAIT;
        ST_WAIT: begin
          if (ackHit) begin
            state    <= ST_LOAD;
            retryCnt <= '0;
          end else if (toHit) begin
            if (retryCnt == RW'(MAX_RETRY)) begin
              state    <= ST_LOAD;
              retryCnt <= '0;
              retryErr <= 1'b1;
            end else begin
              state    <= ST_SEND;
              retryCnt <= retryCnt + 1'b1;
            end
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/inRetryBuf.sv
module inRetryBuf
  import inRetryPkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MAX_RETRY = 3,
  parameter int EP_W      = 4,
  parameter int EP_ID     = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ldValid,
  input  logic [7:0]      ldData,
  input  logic            ldLast,
  output logic            ldReady,
  output logic            fifoWe,
  output logic [7:0]      fifoDin,
  input  logic            fifoFull,
  input  logic            toPulse,
  input  logic            ackPulse,
  input  logic [EP_W-1:0] epSel,
  output logic            retryErr
);
  ctlStrb_t strb;
  logic loadLast, sendDone, epMatch;

  assign epMatch = (epSel == EP_W'(EP_ID));

  inRetryCtl #(.MAX_RETRY(MAX_RETRY)) uCtl (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .loadLast(loadLast),
    .sendDone(sendDone), .fifoFull(fifoFull),
    .toHit(toPulse && epMatch), .ackHit(ackPulse && epMatch),
    .ldReady(ldReady), .fifoWe(fifoWe), .retryErr(retryErr), .strb(strb)
  );

  inRetryData #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .ldData(ldData), .ldLast(ldLast),
    .loadLast(loadLast), .sendDone(sendDone), .fifoDin(fifoDin)
  );
endmodule

// File: rtl/inRetryChk.sv
module inRetryChk #(
  parameter int EP_W  = 4,
  parameter int EP_ID = 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            ldReady,
  input logic            fifoWe,
  input logic            fifoFull,
  input logic            toPulse,
  input logic            ackPulse,
  input logic [EP_W-1:0] epSel,
  input logic            retryErr
);
  logic waiting;
  assign waiting = !ldReady && !fifoWe && !fifoFull;

  // R7
  full_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !fifoWe);

  // R3
  busy_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWe |-> !ldReady);

  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    retryErr |=> retryErr);

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && ackPulse && epSel == EP_W'(EP_ID)) |=> ldReady);

  // R6
  foreign_ep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && epSel != EP_W'(EP_ID)) |=> (!ldReady && !fifoWe));
endmodule

bind inRetryBuf inRetryChk #(.EP_W(EP_W), .EP_ID(EP_ID)) uChk (
  .clk(clk), .rstN(rstN), .ldReady(ldReady), .fifoWe(fifoWe),
  .fifoFull(fifoFull), .toPulse(toPulse), .ackPulse(ackPulse),
  .epSel(epSel), .retryErr(retryErr)
);

// File: tb/test_inRetryBuf.sv
module test_inRetryBuf;
  localparam int DEPTH = 64;
  localparam int MAXR  = 2;
  localparam int EP    = 2;

  logic clk = 0, rstN = 0;
  logic ldValid = 0, ldLast = 0, fifoFull = 0, toPulse = 0, ackPulse = 0;
  logic [7:0] ldData = 0;
  logic [3:0] epSel = 0;
  logic ldReady, fifoWe, retryErr;
  logic [7:0] fifoDin;

  int checks = 0, errors = 0;
  logic [7:0] cap [256];
  int capN = 0;

  // {length, seed}
  localparam int NV = 4;
  localparam int VEC [NV][2] = '{'{1, 8'h11}, '{5, 8'hA0}, '{17, 8'h3C}, '{64, 8'h07}};

  always #5 clk = ~clk;

  inRetryBuf #(.DEPTH(DEPTH), .MAX_RETRY(MAXR), .EP_W(4), .EP_ID(EP)) i_inRetryBuf (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldData(ldData), .ldLast(ldLast),
    .ldReady(ldReady), .fifoWe(fifoWe), .fifoDin(fifoDin), .fifoFull(fifoFull),
    .toPulse(toPulse), .ackPulse(ackPulse), .epSel(epSel), .retryErr(retryErr)
  );

  always @(negedge clk) if (rstN && fifoWe && capN < 256) begin
    cap[capN] = fifoDin;
    capN++;
  end

  function automatic logic [7:0] byteOf(int seed, int i);
    return 8'(seed + i * 37);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadPkt(int n, int seed);
    for (int i = 0; i < n; i++) begin
      ldValid = 1; ldData = byteOf(seed, i); ldLast = (i == n - 1);
      @(posedge clk); #1;
    end
    ldValid = 0; ldLast = 0;
  endtask

  // wait for n FIFO writes, then confirm no more follow and compare bytes
  task automatic expectPkt(int n, int seed, string req);
    int bad = 0;
    for (int t = 0; t < 400 && capN < n; t++) begin
      @(posedge clk); #1;
    end
    repeat (4) @(posedge clk);
    #1;
    check(capN == n, req, capN, n);
    for (int i = 0; i < n && i < capN; i++)
      if (cap[i] != byteOf(seed, i)) bad++;
    check(bad == 0, req, bad, 0);
    capN = 0;
  endtask

  task automatic pulse(bit to, bit ack, int ep);
    toPulse = to; ackPulse = ack; epSel = 4'(ep);
    @(posedge clk); #1;
    toPulse = 0; ackPulse = 0; epSel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(ldReady == 1 && fifoWe == 0 && retryErr == 0, "R1", {ldReady, fifoWe, retryErr}, 3'b100);
    rstN = 1;
    @(posedge clk); #1;

    // table walk: R2 first send, R3 back-pressure, R4 replay, R5 release
    for (int v = 0; v < NV; v++) begin
      capN = 0;
      loadPkt(VEC[v][0], VEC[v][1]);
      check(ldReady == 0, "R3", ldReady, 0);
      expectPkt(VEC[v][0], VEC[v][1], "R2");
      pulse(1, 0, EP);
      expectPkt(VEC[v][0], VEC[v][1], "R4");
      pulse(0, 1, EP);
      check(ldReady == 1, "R5", ldReady, 1);
    end

    // R3 ignored load while outstanding, R6 foreign endpoint
    loadPkt(4, 8'h55);
    expectPkt(4, 8'h55, "R2");
    ldValid = 1; ldData = 8'hEE; ldLast = 1;
    repeat (3) @(posedge clk);
    #1; ldValid = 0; ldLast = 0;
    pulse(1, 0, EP + 1);
    pulse(0, 1, EP + 1);
    repeat (3) @(posedge clk);
    #1;
    check(capN == 0 && ldReady == 0, "R6", capN, 0);
    pulse(1, 0, EP);
    expectPkt(4, 8'h55, "R3");
    // R11 ack wins over same-cycle timeout
    pulse(1, 1, EP);
    repeat (4) @(posedge clk);
    #1;
    check(capN == 0 && ldReady == 1, "R11", capN, 0);

    // R7 full FIFO stalls and resumes in order
    fifoFull = 1;
    loadPkt(6, 8'h90);
    repeat (5) @(posedge clk);
    #1;
    check(capN == 0, "R7", capN, 0);
    fifoFull = 0;
    @(posedge clk); @(posedge clk); #1;
    fifoFull = 1;
    repeat (3) @(posedge clk);
    #1;
    check(capN == 2, "R7", capN, 2);
    fifoFull = 0;
    expectPkt(6, 8'h90, "R7");

    // R8 retry limit
    pulse(1, 0, EP);
    expectPkt(6, 8'h90, "R8");
    pulse(1, 0, EP);
    expectPkt(6, 8'h90, "R8");
    check(retryErr == 0, "R8", retryErr, 0);
    pulse(1, 0, EP);
    expectPkt(0, 0, "R8");
    check(retryErr == 1 && ldReady == 1, "R8", {retryErr, ldReady}, 2'b11);

    // R9 sticky through another packet and ack
    loadPkt(3, 8'h21);
    expectPkt(3, 8'h21, "R9");
    pulse(0, 1, EP);
    check(retryErr == 1, "R9", retryErr, 1);

    // R10 capacity truncation without ldLast
    begin
      int acc = 0;
      for (int i = 0; i < 70 && ldReady; i++) begin
        ldValid = 1; ldData = byteOf(8'h44, i); ldLast = 0;
        @(posedge clk); #1;
        acc++;
      end
      ldValid = 0;
      check(acc == DEPTH, "R10", acc, DEPTH);
    end
    expectPkt(DEPTH, 8'h44, "R10");
    pulse(0, 1, EP);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule